// File: doc/BRIEF.md
# Upstream Request Packet Sender

This block turns requests from an I/O unit into packets on a 128-bit upstream bus. A local client presents one whole request at a time through a ready/valid handshake. The request carries a kind, a 16-bit transaction tag, an address, a 12-bit attribute field and up to four 128-bit payload words. Once the block accepts a request, it sends a header cycle. Depending on the kind, zero, one or four data beats follow on the cycles right after the header. Then the bus stays quiet for the idle spacing that the kind requires. Only after that does the block take the next request.

The receiver works out the packet type from a 7-bit command. The upper six bits of that command are header bits [127:122], and its least significant bit is a side-band bypass strobe. Two data-request flags, valid only on the header cycle, tell the receiver how many beats follow. Each 32-bit lane of the bus carries an even-parity bit on the header cycle and on every data beat.

Top module: `pkt_req_sender`

## Requirements
- R1: A synchronous active-high reset, applied at any time, returns the block to idle. While reset is held and on the cycles after its release until a new request is accepted: `bus_hdr_vld`, `bus_dreq`, `bus_dreq_short`, `bus_bypass`, `bus_data` and `bus_par` are all zero, and `req_ready` is 1.
- R2: `req_ready` is 1 only while the block is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. The header appears on the bus during the cycle right after that edge.
- R3: The `req_kind` encoding is 0 read, 1 write-invalidate, 2 write-merge, 3 interrupt and 4 bypass PIO. The 7-bit command {bus_data[127:122], bus_bypass} sent on the header cycle is:
  - 0010100 for a read
  - 0100100 for a write-invalidate
  - 0101100 for a write-merge
  - 0000010 for an interrupt
  - {1, sel[1], 1, sel[0], 0, 1, 1} for a PIO, where sel is `req_pio_sel`
- R4: On the header cycle, a read drives `bus_dreq`=0 and `bus_dreq_short`=0. Both writes drive `bus_dreq`=1 and `bus_dreq_short`=0. Interrupt and PIO drive both flags to 1. The flags and `bus_bypass` are 0 on every other cycle.
- R5: The header carries the tag in bits [79:64] and the address in bits [39:6]. Attribute bits [11:7] go to header bits [84:80] and attribute bits [6:0] go to bits [62:56]. Bits [121:85], bit 63, bits [55:40] and bits [5:0] are zero.
- R6: Data beat i (counting from 0) carries `req_payload[128*i +: 128]`. A write sends beats 0 to 3 on the four cycles after the header. An interrupt or PIO sends beat 0 on the cycle after the header. `bus_data` is zero on every cycle that is neither a header nor a beat.
- R7: After the last beat of a single-beat packet, the bus is idle for 1 cycle. After the last beat of a four-beat packet, it is idle for 4 cycles. During those cycles `bus_hdr_vld`, both data-request flags, `bus_data` and `req_ready` are 0. `req_ready` returns to 1 on the next cycle. A read has no gap, so `req_ready` returns on the cycle after its header.
- R8: `bus_par[k]` makes {bus_data[32k+31:32k], bus_par[k]} even parity for k = 0 to 3. This holds on header cycles, on data beats and on quiet cycles.
- R9: `req_kind` values 5, 6 and 7 are sent as a read request.
- R10: Changes on the request inputs while the block is busy have no effect. This holds even with `req_valid` held high: no new header appears, and the beats in flight keep the payload captured when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 3 | Request kind code |
| req_pio_sel | input | 2 | Free command bits for a PIO request |
| req_tag | input | 16 | Transaction tag |
| req_addr | input | 34 | Address, 64-byte granule |
| req_attr | input | 12 | Attribute bits placed in the header |
| req_payload | input | 512 | Four 128-bit payload words, word 0 in the low bits |
| bus_hdr_vld | output | 1 | Header cycle strobe |
| bus_dreq | output | 1 | Data follows the header |
| bus_dreq_short | output | 1 | Exactly one data beat follows |
| bus_bypass | output | 1 | Side-band low bit of the command |
| bus_data | output | 128 | Header or data beat |
| bus_par | output | 4 | Even parity per 32-bit lane |

## Verification
The main function is driven with one request of every kind. These requests tell apart the three beat and gap shapes, and the two write codes that differ in only one bit. PIO requests with three different select values confirm that the free command bits are routed to their own header positions and not to the fixed bits next to them. An out-of-range kind, a reset mid-packet and a busy period with `req_valid` held high and changed payload show that the decode default, the recovery and the input capture behave as required. Tags and addresses include all-ones, all-zeros and alternating patterns so that every parity lane is seen both set and clear.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
    localparam int BUS_W  = 128;
    localparam int TAG_W  = 16;
    localparam int ADDR_W = 34;
    localparam int ATTR_W = 12;
    localparam int KIND_W = 3;
    localparam int SEL_W  = 2;

    typedef enum logic [KIND_W-1:0] {
        K_READ  = 3'd0,
        K_WRINV = 3'd1,
        K_WRMRG = 3'd2,
        K_INTR  = 3'd3,
        K_PIO   = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA,
        PH_GAP
    } phase_e;

    typedef struct packed {
        logic [5:0] op;
        logic       bypass;
        logic       dreq;
        logic       dreq_short;
    } cmd_t;

    // counter width able to hold the largest of three lengths
    function automatic int cnt_w(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        m = (m > c) ? m : c;
        return (m < 1) ? 1 : $clog2(m + 1);
    endfunction

    // out-of-range kinds fall through to a read
    function automatic cmd_t decode_kind(input logic [KIND_W-1:0] kind,
                                         input logic [SEL_W-1:0]  sel);
        cmd_t c;
        case (kind)
            K_WRINV: c = '{op: 6'b010010, bypass: 1'b0, dreq: 1'b1, dreq_short: 1'b0};
            K_WRMRG: c = '{op: 6'b010110, bypass: 1'b0, dreq: 1'b1, dreq_short: 1'b0};
            K_INTR:  c = '{op: 6'b000001, bypass: 1'b0, dreq: 1'b1, dreq_short: 1'b1};
            K_PIO:   c = '{op: {1'b1, sel[1], 1'b1, sel[0], 2'b01},
                           bypass: 1'b1, dreq: 1'b1, dreq_short: 1'b1};
            default: c = '{op: 6'b001010, bypass: 1'b0, dreq: 1'b0, dreq_short: 1'b0};
        endcase
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] build_hdr(input cmd_t c,
                                                   input logic [TAG_W-1:0]  tag,
                                                   input logic [ADDR_W-1:0] addr,
                                                   input logic [ATTR_W-1:0] attr);
        logic [BUS_W-1:0] h;
        h          = '0;
        h[127:122] = c.op;
        h[84:80]   = attr[11:7];
        h[79:64]   = tag;
        h[62:56]   = attr[6:0];
        h[39:6]    = addr;
        return h;
    endfunction
endpackage

// File: rtl/pkt_lane_par.sv
module pkt_lane_par #(
    parameter int W     = 128,
    parameter int LANES = 4,
    localparam int LW   = W / LANES
) (
    input  logic [W-1:0]     data,
    output logic [LANES-1:0] par
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = ^data[i*LW +: LW];
    end
endmodule

// File: rtl/pkt_capture.sv
module pkt_capture
    import pkt_pkg::*;
#(
    parameter int PAY_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  cmd_t              cmd_in,
    input  logic [TAG_W-1:0]  tag,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ATTR_W-1:0] attr,
    input  logic [PAY_W-1:0]  payload,
    output logic [BUS_W-1:0]  hdr_q,
    output logic [PAY_W-1:0]  pay_q,
    output logic              dreq_q,
    output logic              short_q,
    output logic              bypass_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q    <= '0;
            pay_q    <= '0;
            dreq_q   <= 1'b0;
            short_q  <= 1'b0;
            bypass_q <= 1'b0;
        end else if (load) begin
            hdr_q    <= build_hdr(cmd_in, tag, addr, attr);
            pay_q    <= payload;
            dreq_q   <= cmd_in.dreq;
            short_q  <= cmd_in.dreq_short;
            bypass_q <= cmd_in.bypass;
        end
    end

    // R10: captured payload only moves on an accepted request
    a_r10_hold_payload: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pay_q));
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
    import pkt_pkg::*;
#(
    parameter int LONG_BEATS = 4,
    parameter int LONG_GAP   = 4,
    parameter int SHORT_GAP  = 1,
    localparam int CW        = cnt_w(LONG_BEATS, LONG_GAP, SHORT_GAP)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          has_data,
    input  logic          short_pkt,
    output logic          ready,
    output phase_e        phase,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] beats_q;
    logic [CW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            beats_q <= '0;
            gap_q   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        phase   <= PH_HDR;
                        beats_q <= has_data ? (short_pkt ? CW'(1) : CW'(LONG_BEATS)) : '0;
                        gap_q   <= has_data ? (short_pkt ? CW'(SHORT_GAP) : CW'(LONG_GAP)) : '0;
                    end
                end
                PH_HDR: begin
                    cnt <= '0;
                    if (beats_q != '0)
                        phase <= PH_DATA;
                    else if (gap_q != '0)
                        phase <= PH_GAP;
                    else
                        phase <= PH_IDLE;
                end
                PH_DATA: begin
                    if (cnt == beats_q - 1'b1) begin
                        cnt   <= '0;
                        phase <= (gap_q != '0) ? PH_GAP : PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == gap_q - 1'b1) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign ready = (phase == PH_IDLE);

    // R1: first cycle out of reset is idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> phase == PH_IDLE);
    // R2: an accepted request is followed by a header cycle
    a_r2_hdr_follows_accept: assert property (@(posedge clk) disable iff (rst)
        start |=> phase == PH_HDR);
    // R2: no header without an accepted request
    a_r2_hdr_needs_accept: assert property (@(posedge clk) disable iff (rst)
        phase == PH_HDR |-> $past(start));
    // R7: gap counter stays inside the programmed gap
    a_r7_gap_bounded: assert property (@(posedge clk) disable iff (rst)
        phase == PH_GAP |-> cnt < gap_q);
endmodule

// File: rtl/pkt_req_sender.sv
module pkt_req_sender
    import pkt_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LONG_BEATS = 4,
    parameter int LONG_GAP   = 4,
    parameter int SHORT_GAP  = 1,
    localparam int PAY_W     = BUS_W * LONG_BEATS,
    localparam int CW        = cnt_w(LONG_BEATS, LONG_GAP, SHORT_GAP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [SEL_W-1:0]  req_pio_sel,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ATTR_W-1:0] req_attr,
    input  logic [PAY_W-1:0]  req_payload,
    output logic              bus_hdr_vld,
    output logic              bus_dreq,
    output logic              bus_dreq_short,
    output logic              bus_bypass,
    output logic [BUS_W-1:0]  bus_data,
    output logic [LANES-1:0]  bus_par
);
    cmd_t             cmd_in;
    logic             start;
    logic [BUS_W-1:0] hdr_q;
    logic [PAY_W-1:0] pay_q;
    logic             dreq_q;
    logic             short_q;
    logic             bypass_q;
    phase_e           phase;
    logic [CW-1:0]    cnt;

    assign cmd_in = decode_kind(req_kind, req_pio_sel);
    assign start  = req_valid & req_ready;

    pkt_capture #(.PAY_W(PAY_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .cmd_in   (cmd_in),
        .tag      (req_tag),
        .addr     (req_addr),
        .attr     (req_attr),
        .payload  (req_payload),
        .hdr_q    (hdr_q),
        .pay_q    (pay_q),
        .dreq_q   (dreq_q),
        .short_q  (short_q),
        .bypass_q (bypass_q)
    );

    pkt_seq #(
        .LONG_BEATS (LONG_BEATS),
        .LONG_GAP   (LONG_GAP),
        .SHORT_GAP  (SHORT_GAP)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .has_data  (cmd_in.dreq),
        .short_pkt (cmd_in.dreq_short),
        .ready     (req_ready),
        .phase     (phase),
        .cnt       (cnt)
    );

    always_comb begin
        bus_hdr_vld    = (phase == PH_HDR);
        bus_dreq       = bus_hdr_vld & dreq_q;
        bus_dreq_short = bus_hdr_vld & short_q;
        bus_bypass     = bus_hdr_vld & bypass_q;
        case (phase)
            PH_HDR:  bus_data = hdr_q;
            PH_DATA: bus_data = pay_q[int'(cnt)*BUS_W +: BUS_W];
            default: bus_data = '0;
        endcase
    end

    pkt_lane_par #(.W(BUS_W), .LANES(LANES)) u_par (
        .data (bus_data),
        .par  (bus_par)
    );

    // header spacing tracker, used by a_r7_spacing only
    localparam int SW = $clog2(LONG_BEATS + LONG_GAP + SHORT_GAP + 3) + 1;
    logic [SW-1:0] since_q;
    logic [SW-1:0] need_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
            need_q  <= '0;
            seen_q  <= 1'b0;
        end else if (bus_hdr_vld) begin
            since_q <= SW'(1);
            seen_q  <= 1'b1;
            need_q  <= !bus_dreq ? SW'(1) :
                       bus_dreq_short ? SW'(2 + SHORT_GAP) : SW'(1 + LONG_BEATS + LONG_GAP);
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    logic [6:0] cmd7;
    assign cmd7 = {bus_data[127:122], bus_bypass};

    // R7: next header no earlier than beats plus gap after the last one
    a_r7_spacing: assert property (@(posedge clk) disable iff (rst)
        bus_hdr_vld && seen_q |-> since_q >= need_q);
    // R3: only legal command codes are sent
    a_r3_cmd_legal: assert property (@(posedge clk) disable iff (rst)
        bus_hdr_vld |-> (cmd7 == 7'b0100100 || cmd7 == 7'b0101100 ||
                         cmd7 == 7'b0010100 || cmd7 == 7'b0000010 ||
                         (cmd7[6] && cmd7[4] && cmd7[2:0] == 3'b011)));
    // R4: bypass implies a single-beat data packet
    a_r4_bypass_flags: assert property (@(posedge clk) disable iff (rst)
        bus_bypass |-> bus_hdr_vld && bus_dreq && bus_dreq_short);
    // R4: short flag never without the data flag
    a_r4_short_needs_dreq: assert property (@(posedge clk) disable iff (rst)
        bus_dreq_short |-> bus_dreq);
    // R5: reserved header fields are zero
    a_r5_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        bus_hdr_vld |-> (bus_data[121:85] == '0 && !bus_data[63] &&
                         bus_data[55:40] == '0 && bus_data[5:0] == '0));
    // R8: even parity on every lane
    a_r8_parity: assert property (@(posedge clk) disable iff (rst)
        (^{bus_data[127:96], bus_par[3]}) == 1'b0 && (^{bus_data[95:64], bus_par[2]}) == 1'b0 &&
        (^{bus_data[63:32], bus_par[1]}) == 1'b0 && (^{bus_data[31:0], bus_par[0]}) == 1'b0);
    // R2: no bus activity reported while ready
    a_r2_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !bus_hdr_vld && bus_data == '0);
endmodule

// File: tb/sim_pkt_req_sender.sv
`timescale 1ns/1ps
module sim_pkt_req_sender;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_kind = '0;
    logic [1:0]   req_pio_sel = '0;
    logic [15:0]  req_tag = '0;
    logic [33:0]  req_addr = '0;
    logic [11:0]  req_attr = '0;
    logic [511:0] req_payload = '0;
    logic         bus_hdr_vld, bus_dreq, bus_dreq_short, bus_bypass;
    logic [127:0] bus_data;
    logic [3:0]   bus_par;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pkt_req_sender u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_pio_sel(req_pio_sel), .req_tag(req_tag),
        .req_addr(req_addr), .req_attr(req_attr), .req_payload(req_payload),
        .bus_hdr_vld(bus_hdr_vld), .bus_dreq(bus_dreq), .bus_dreq_short(bus_dreq_short),
        .bus_bypass(bus_bypass), .bus_data(bus_data), .bus_par(bus_par)
    );

    // {kind,sel,tag,addr,attr,exp_cmd7,exp_beats,exp_gap,exp_dreq,exp_short}
    localparam int VW = 82;
    localparam logic [VW-1:0] VEC [8] = '{
        {3'd0, 2'b00, 16'h1001, 34'h0_0000_0040, 12'h000, 7'b0010100, 3'd0, 3'd0, 1'b0, 1'b0},
        {3'd1, 2'b00, 16'h2A5F, 34'h2_5555_AAAA, 12'hFFF, 7'b0100100, 3'd4, 3'd4, 1'b1, 1'b0},
        {3'd2, 2'b11, 16'hFFFF, 34'h3_FFFF_FFFF, 12'h801, 7'b0101100, 3'd4, 3'd4, 1'b1, 1'b0},
        {3'd3, 2'b01, 16'h0000, 34'h1_0203_0405, 12'h07F, 7'b0000010, 3'd1, 3'd1, 1'b1, 1'b1},
        {3'd4, 2'b00, 16'hBEEF, 34'h0_DEAD_BEEF, 12'h123, 7'b1010011, 3'd1, 3'd1, 1'b1, 1'b1},
        {3'd4, 2'b11, 16'h7E57, 34'h1_1111_1111, 12'hAAA, 7'b1111011, 3'd1, 3'd1, 1'b1, 1'b1},
        {3'd4, 2'b10, 16'h00F0, 34'h2_0F0F_0F0F, 12'h555, 7'b1110011, 3'd1, 3'd1, 1'b1, 1'b1},
        {3'd6, 2'b11, 16'h0C0D, 34'h0_8000_0001, 12'h3C3, 7'b0010100, 3'd0, 3'd0, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [511:0] make_pay(input logic [15:0] tag);
        logic [511:0] p;
        for (int i = 0; i < 4; i++)
            p[i*128 +: 128] = {4{tag ^ 16'(i * 16'h1111), 16'h5A00 | 16'(i)}};
        return p;
    endfunction

    function automatic logic [3:0] exp_par(input logic [127:0] d);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ^d[k*32 +: 32];
        return p;
    endfunction

    task automatic quiet_chk(input string what);
        chk(bus_hdr_vld == 0 && bus_dreq == 0 && bus_dreq_short == 0 && bus_bypass == 0,
            what, {bus_hdr_vld, bus_dreq, bus_dreq_short, bus_bypass}, 0);
        chk(bus_data == '0 && bus_par == '0, what, bus_data ^ 128'(bus_par), 0);
    endtask

    task automatic run_pkt(input logic [VW-1:0] v, input bit disturb);
        logic [2:0]   kind;
        logic [1:0]   sel;
        logic [15:0]  tag;
        logic [33:0]  addr;
        logic [11:0]  attr;
        logic [6:0]   ecmd;
        int           beats, gap;
        logic         edreq, eshort;
        logic [127:0] ehdr;
        logic [511:0] pay;
        kind = v[81:79]; sel = v[78:77]; tag = v[76:61]; addr = v[60:27];
        attr = v[26:15]; ecmd = v[14:8]; beats = int'(v[7:5]); gap = int'(v[4:2]);
        edreq = v[1]; eshort = v[0];
        pay  = make_pay(tag);
        ehdr = '0;
        ehdr[127:122] = ecmd[6:1];
        ehdr[84:80] = attr[11:7];
        ehdr[79:64] = tag;
        ehdr[62:56] = attr[6:0];
        ehdr[39:6]  = addr;

        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when idle", 128'(req_ready), 1);
        req_kind = kind; req_pio_sel = sel; req_tag = tag; req_addr = addr;
        req_attr = attr; req_payload = pay; req_valid = 1'b1;
        @(negedge clk);
        if (disturb) begin
            req_payload = ~pay; req_tag = ~tag; req_kind = 3'd0;
        end else begin
            req_valid = 1'b0;
        end
        chk(bus_hdr_vld == 1'b1, "R2 header one cycle after accept", 128'(bus_hdr_vld), 1);
        chk({bus_data[127:122], bus_bypass} == ecmd, "R3 command code (R9 for kind 6)",
            128'({bus_data[127:122], bus_bypass}), 128'(ecmd));
        chk(bus_dreq == edreq && bus_dreq_short == eshort, "R4 data request flags",
            128'({bus_dreq, bus_dreq_short}), 128'({edreq, eshort}));
        chk(bus_data == ehdr, "R5 header layout", bus_data, ehdr);
        chk(bus_par == exp_par(ehdr), "R8 header parity", 128'(bus_par), 128'(exp_par(ehdr)));
        for (int i = 0; i < beats; i++) begin
            @(negedge clk);
            chk(bus_data == pay[i*128 +: 128], disturb ? "R10 beat keeps captured payload" : "R6 data beat",
                bus_data, pay[i*128 +: 128]);
            chk(bus_hdr_vld == 0 && bus_dreq == 0 && bus_dreq_short == 0 && bus_bypass == 0,
                disturb ? "R10 no header while busy" : "R4 flags low on beat",
                128'({bus_hdr_vld, bus_dreq, bus_dreq_short, bus_bypass}), 0);
            chk(bus_par == exp_par(pay[i*128 +: 128]), "R8 beat parity", 128'(bus_par),
                128'(exp_par(pay[i*128 +: 128])));
            chk(req_ready == 1'b0, "R2 not ready on beat", 128'(req_ready), 0);
        end
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            quiet_chk("R7 idle gap after beats");
            chk(req_ready == 1'b0, "R7 not ready in gap", 128'(req_ready), 0);
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready after gap", 128'(req_ready), 1);
        quiet_chk("R6 bus zero when idle");
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=%0d cycles expected=under 20000", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        quiet_chk("R1 outputs zero in reset");
        chk(req_ready == 1'b1, "R1 ready in reset", 128'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        quiet_chk("R1 outputs zero after reset");
        chk(req_ready == 1'b1, "R1 ready after reset", 128'(req_ready), 1);

        // table walk
        for (int n = 0; n < 8; n++) run_pkt(VEC[n], 1'b0);

        // R10: inputs changed and valid held while busy
        run_pkt(VEC[1], 1'b1);

        // R1: reset in the middle of a four-beat packet
        @(negedge clk);
        req_kind = 3'd1; req_tag = 16'h3333; req_payload = make_pay(16'h3333); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        quiet_chk("R1 reset mid packet clears bus");
        chk(req_ready == 1'b1, "R1 ready after mid packet reset", 128'(req_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        quiet_chk("R1 stays quiet after release");
        run_pkt(VEC[3], 1'b0);

        finish_run();
    end
endmodule